// File: doc/BRIEF.md
# Start-up Mode and Boot Reference Sequencer

This block is the start-up controller of a two-output voltage regulator: a multiphase core output and a single-phase auxiliary output. Once power-on-reset reports valid supplies, it records how many core phases are fitted from three strap flags. On a qualified rising edge of enable it records the interface mode (parallel code or serial command) and the boot-voltage strap pair. It then produces one digital reference code per output section and moves each one toward its target one step at a time. All codes are in 12.5 mV units, so 88 stands for 1.1 V and 124 for 1.55 V.

The target of each section comes from a fixed order of sources. In parallel mode only the core is driven, from a 6-bit input code, and the auxiliary output is flagged high-impedance. In serial mode a debug fix-enable strap takes precedence and picks a fixed voltage live from the strap pair. Without it, the latched boot voltage applies until power-ok rises. After that, the per-section targets delivered by the serial command receiver apply. Converting the codes to analog voltages is done elsewhere.

Top module: `startup_ref_seq`

## Requirements
- R1: A rising edge of `en` seen while `por` is high sets `active` and latches `mode_strap` into `par_mode` (1 = parallel, 0 = serial); a rising edge of `en` while `por` is low leaves `active` at 0; `par_mode` does not change while `active` stays high.
- R2: On the rising edge of `por` the phase count is latched from `ph_flags` (bit 0 = channel 2 pulled high, bit 1 = channel 3, bit 2 = channel 4), the lowest flagged channel winning: bit 0 gives 1, else bit 1 gives 2, else bit 2 gives 3, none gives 4; later flag changes while `por` stays high have no effect.
- R3: In parallel mode the core target is 124 - 2*c for `par_code` c in 0..31 (1.55 V falling by 25 mV per code) and 93 - c for c in 32..63 (0.7625 V falling by 12.5 mV per code).
- R4: In parallel mode `aux_hiz` is 1, `aux_ref` is 0, and `pwrok`, `fix_en` and the serial targets have no effect on `core_ref`.
- R5: In serial mode with `fix_en` low and `pwrok` low, both targets come from `boot_pins` as latched at the enabling edge: 00 gives 88, 01 gives 80, 10 gives 72, 11 gives 64; later pin changes have no effect.
- R6: In serial mode with `fix_en` low and `pwrok` high, each section's target is 124 - c for its serial code c below 124, and 0 (section off) for codes 124..127; one section may be off while the other is regulated.
- R7: In serial mode with `fix_en` high, both targets follow the live `boot_pins` whatever `pwrok` is: 00 gives 112, 01 gives 96, 10 gives 80, 11 gives 64.
- R8: Each reference moves by exactly one code per `STEP_DIV` clocks toward its target, never by more than one code in a clock while active, and stops when it equals the target.
- R9: When `en` or `por` is low, `active` and `par_mode` clear at the next clock and both references read 0 one clock later; a low `por` also clears `phase_cnt` to 0.
- R10: After `rst_n` is asserted all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por | input | 1 | Supplies valid |
| en | input | 1 | Controller enable |
| pwrok | input | 1 | Processor power-ok, hands control to serial targets |
| mode_strap | input | 1 | Interface mode strap, sampled at enable |
| fix_en | input | 1 | Debug fixed-voltage strap |
| boot_pins | input | 2 | Boot / fixed voltage strap pair |
| ph_flags | input | NUM_PH-1 | Per-channel pulled-high flags, channel 2 upward |
| par_code | input | 6 | Parallel voltage code |
| cmd_core | input | 7 | Serial target code for the core section |
| cmd_aux | input | 7 | Serial target code for the auxiliary section |
| core_ref | output | REF_W | Core reference code, 12.5 mV units |
| aux_ref | output | REF_W | Auxiliary reference code, 12.5 mV units |
| aux_hiz | output | 1 | Auxiliary output held high-impedance |
| phase_cnt | output | PH_W | Number of active core phases, 0 before latching |
| par_mode | output | 1 | 1 = parallel mode |
| active | output | 1 | Sequencer enabled |

## Verification
The bench pushes both ends and the bend of the parallel code curve (0, 31, 32, 63). A decoder with the break off by one, or one that applied the 25 mV step throughout, would land on the wrong code. It moves the boot straps after the enabling edge, where a sequencer that read them live would drift away from the boot value. It also moves them with fix-enable high, where one that latched them would freeze. It raises `pwrok` in parallel mode to catch a design that lets serial targets leak into the core. It turns one serial section off while the other stays up, which catches shared off logic. It cycles `por` with several flag patterns to expose a wrong phase priority or a count that does not clear. A mid-ramp window check catches a ramp that jumps or steps at the wrong rate.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

   // Target source chosen for a section
   typedef enum logic [2:0] {
      SRC_OFF  = 3'd0,
      SRC_PAR  = 3'd1,
      SRC_BOOT = 3'd2,
      SRC_FIX  = 3'd3,
      SRC_CMD  = 3'd4
   } src_e;

   // Highest code value produced by any decoder (1.55 V / 12.5 mV)
   localparam int unsigned TOP_STEP = 124;

   // Parallel 6-bit code: 25 mV steps for the upper half, 12.5 mV below
   function automatic int unsigned par_to_step(input logic [5:0] c);
      if (c < 6'd32) return TOP_STEP - 2 * int'(c);
      else           return 93 - int'(c);
   endfunction

   // Serial 7-bit code: 12.5 mV steps, top four codes switch off
   function automatic int unsigned ser_to_step(input logic [6:0] c);
      if (int'(c) >= TOP_STEP) return 0;
      else                     return TOP_STEP - int'(c);
   endfunction

   // Boot voltage from strap pair: 1.1 V down in 100 mV steps
   function automatic int unsigned boot_step(input logic [1:0] s);
      return 88 - 8 * int'(s);
   endfunction

   // Debug fixed voltage from strap pair: 1.4 V down in 200 mV steps
   function automatic int unsigned fix_step(input logic [1:0] s);
      return 112 - 16 * int'(s);
   endfunction

endpackage

// File: rtl/seq_strap_latch.sv
module seq_strap_latch #(
   parameter int NUM_PH = 4,
   localparam int PH_W  = $clog2(NUM_PH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por,
   input  logic              en,
   input  logic              mode_strap,
   input  logic [1:0]        boot_pins,
   input  logic [NUM_PH-2:0] ph_flags,
   output logic              active,
   output logic              par_mode,
   output logic [1:0]        boot_lat,
   output logic [PH_W-1:0]   phase_cnt
);

   logic por_q;
   logic en_q;
   logic drop;
   logic en_rise;
   logic por_rise;
   logic [PH_W-1:0] ph_pick;

   assign drop     = ~en | ~por;
   assign en_rise  = en & ~en_q;
   assign por_rise = por & ~por_q;

   // Lowest pulled-high channel decides the count
   always_comb begin
      ph_pick = PH_W'(NUM_PH);
      for (int i = NUM_PH - 2; i >= 0; i--) begin
         if (ph_flags[i]) ph_pick = PH_W'(i + 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_q     <= 1'b0;
         en_q      <= 1'b0;
         active    <= 1'b0;
         par_mode  <= 1'b0;
         boot_lat  <= 2'b00;
         phase_cnt <= '0;
      end else begin
         por_q <= por;
         en_q  <= en;
         if (!por)          phase_cnt <= '0;
         else if (por_rise) phase_cnt <= ph_pick;
         if (drop) begin
            active   <= 1'b0;
            par_mode <= 1'b0;
            boot_lat <= 2'b00;
         end else if (en_rise) begin
            active   <= 1'b1;
            par_mode <= mode_strap;
            boot_lat <= boot_pins;
         end
      end
   end

endmodule

// File: rtl/seq_target_sel.sv
module seq_target_sel
   import startup_seq_pkg::*;
#(
   parameter int REF_W = 7
) (
   input  logic             active,
   input  logic             par_mode,
   input  logic             fix_en,
   input  logic             pwrok,
   input  logic [1:0]       boot_pins,
   input  logic [1:0]       boot_lat,
   input  logic [5:0]       par_code,
   input  logic [6:0]       cmd_core,
   input  logic [6:0]       cmd_aux,
   output logic [REF_W-1:0] tgt_core,
   output logic [REF_W-1:0] tgt_aux,
   output logic             aux_hiz
);

   src_e src;

   // Source priority: disabled, parallel, fixed, command, boot
   always_comb begin
      if (!active)      src = SRC_OFF;
      else if (par_mode) src = SRC_PAR;
      else if (fix_en)  src = SRC_FIX;
      else if (pwrok)   src = SRC_CMD;
      else              src = SRC_BOOT;
   end

   always_comb begin
      tgt_core = '0;
      tgt_aux  = '0;
      unique case (src)
         SRC_PAR:  tgt_core = REF_W'(par_to_step(par_code));
         SRC_FIX: begin
            tgt_core = REF_W'(fix_step(boot_pins));
            tgt_aux  = REF_W'(fix_step(boot_pins));
         end
         SRC_CMD: begin
            tgt_core = REF_W'(ser_to_step(cmd_core));
            tgt_aux  = REF_W'(ser_to_step(cmd_aux));
         end
         SRC_BOOT: begin
            tgt_core = REF_W'(boot_step(boot_lat));
            tgt_aux  = REF_W'(boot_step(boot_lat));
         end
         default: begin
            tgt_core = '0;
            tgt_aux  = '0;
         end
      endcase
   end

   assign aux_hiz = (src == SRC_PAR);

endmodule

// File: rtl/seq_ramp.sv
module seq_ramp #(
   parameter int REF_W    = 7,
   parameter int STEP_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [REF_W-1:0] tgt,
   output logic [REF_W-1:0] ref_q
);

   logic up;
   logic at_tgt;

   assign at_tgt = (ref_q == tgt);
   assign up     = (tgt > ref_q);

   generate
      if (STEP_DIV == 1) begin : g_every_clk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ref_q <= '0;
            else if (clr)    ref_q <= '0;
            else if (!at_tgt) ref_q <= up ? ref_q + 1'b1 : ref_q - 1'b1;
         end
      end else begin : g_divided
         localparam int CNT_W = $clog2(STEP_DIV);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_DIV - 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ref_q <= '0;
               cnt   <= '0;
            end else if (clr) begin
               ref_q <= '0;
               cnt   <= '0;
            end else if (at_tgt) begin
               cnt <= '0;
            end else if (cnt == CNT_LAST) begin
               cnt   <= '0;
               ref_q <= up ? ref_q + 1'b1 : ref_q - 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/startup_ref_seq.sv
module startup_ref_seq #(
   parameter int NUM_PH   = 4,
   parameter int REF_W    = 7,
   parameter int STEP_DIV = 4,
   localparam int PH_W    = $clog2(NUM_PH + 1),
   localparam int N_SEC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por,
   input  logic              en,
   input  logic              pwrok,
   input  logic              mode_strap,
   input  logic              fix_en,
   input  logic [1:0]        boot_pins,
   input  logic [NUM_PH-2:0] ph_flags,
   input  logic [5:0]        par_code,
   input  logic [6:0]        cmd_core,
   input  logic [6:0]        cmd_aux,
   output logic [REF_W-1:0]  core_ref,
   output logic [REF_W-1:0]  aux_ref,
   output logic              aux_hiz,
   output logic [PH_W-1:0]   phase_cnt,
   output logic              par_mode,
   output logic              active
);

   generate
      if (NUM_PH < 2)   begin : g_bad_ph  $error("NUM_PH must be at least 2");   end
      if (REF_W < 7)    begin : g_bad_w   $error("REF_W must hold code 124");    end
      if (STEP_DIV < 1) begin : g_bad_div $error("STEP_DIV must be positive");   end
   endgenerate

   logic [1:0]       boot_lat;
   logic [REF_W-1:0] tgt   [N_SEC];
   logic [REF_W-1:0] refs  [N_SEC];

   seq_strap_latch #(.NUM_PH(NUM_PH)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .por        (por),
      .en         (en),
      .mode_strap (mode_strap),
      .boot_pins  (boot_pins),
      .ph_flags   (ph_flags),
      .active     (active),
      .par_mode   (par_mode),
      .boot_lat   (boot_lat),
      .phase_cnt  (phase_cnt)
   );

   seq_target_sel #(.REF_W(REF_W)) u_sel (
      .active    (active),
      .par_mode  (par_mode),
      .fix_en    (fix_en),
      .pwrok     (pwrok),
      .boot_pins (boot_pins),
      .boot_lat  (boot_lat),
      .par_code  (par_code),
      .cmd_core  (cmd_core),
      .cmd_aux   (cmd_aux),
      .tgt_core  (tgt[0]),
      .tgt_aux   (tgt[1]),
      .aux_hiz   (aux_hiz)
   );

   for (genvar g = 0; g < N_SEC; g++) begin : g_sec
      seq_ramp #(.REF_W(REF_W), .STEP_DIV(STEP_DIV)) u_ramp (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (~active),
         .tgt   (tgt[g]),
         .ref_q (refs[g])
      );
   end

   assign core_ref = refs[0];
   assign aux_ref  = refs[1];

endmodule

// File: rtl/startup_ref_seq_chk.sv
module startup_ref_seq_chk #(
   parameter int REF_W = 7,
   parameter int PH_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             por,
   input logic             active,
   input logic             par_mode,
   input logic             aux_hiz,
   input logic [REF_W-1:0] core_ref,
   input logic [REF_W-1:0] aux_ref,
   input logic [PH_W-1:0]  phase_cnt
);

   // R8
   core_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && $past(active) |->
         (core_ref == $past(core_ref)) || (core_ref == $past(core_ref) + 1'b1) ||
         (core_ref + 1'b1 == $past(core_ref)));

   // R8
   aux_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && $past(active) |->
         (aux_ref == $past(aux_ref)) || (aux_ref == $past(aux_ref) + 1'b1) ||
         (aux_ref + 1'b1 == $past(aux_ref)));

   // R9
   idle_refs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (core_ref == '0) && (aux_ref == '0));

   // R4
   hiz_aux_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aux_hiz |-> (aux_ref == '0) && par_mode);

   // R2
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por && $past(por) |=> $stable(phase_cnt));

   // R1
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && $past(active) |-> $stable(par_mode));

   // R3
   core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_ref <= REF_W'(124));

endmodule

bind startup_ref_seq startup_ref_seq_chk #(.REF_W(REF_W), .PH_W(PH_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .por       (por),
   .active    (active),
   .par_mode  (par_mode),
   .aux_hiz   (aux_hiz),
   .core_ref  (core_ref),
   .aux_ref   (aux_ref),
   .phase_cnt (phase_cnt)
);

// File: tb/sim_startup_ref_seq.sv
module sim_startup_ref_seq;

   localparam int CLK_PER  = 10;
   localparam int NUM_PH   = 4;
   localparam int REF_W    = 7;
   localparam int STEP_DIV = 4;
   localparam int SETTLE   = 130 * STEP_DIV;
   localparam int N_VEC    = 6;
   // {par_code, expected core code}
   localparam logic [12:0] PAR_VEC [N_VEC] = '{
      {6'd0,  7'd124}, {6'd31, 7'd62}, {6'd32, 7'd61},
      {6'd63, 7'd30},  {6'd10, 7'd104}, {6'd40, 7'd53}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por = 1'b0, en = 1'b0, pwrok = 1'b0, mode_strap = 1'b0, fix_en = 1'b0;
   logic [1:0] boot_pins = 2'b00;
   logic [NUM_PH-2:0] ph_flags = '0;
   logic [5:0] par_code = '0;
   logic [6:0] cmd_core = '0, cmd_aux = '0;
   logic [REF_W-1:0] core_ref, aux_ref;
   logic aux_hiz, par_mode, active;
   logic [2:0] phase_cnt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PER / 2) clk = ~clk;

   startup_ref_seq #(.NUM_PH(NUM_PH), .REF_W(REF_W), .STEP_DIV(STEP_DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .por(por), .en(en), .pwrok(pwrok),
      .mode_strap(mode_strap), .fix_en(fix_en), .boot_pins(boot_pins),
      .ph_flags(ph_flags), .par_code(par_code), .cmd_core(cmd_core),
      .cmd_aux(cmd_aux), .core_ref(core_ref), .aux_ref(aux_ref),
      .aux_hiz(aux_hiz), .phase_cnt(phase_cnt), .par_mode(par_mode),
      .active(active)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      wait_clk(3);
      // R10 reset state
      chk("R10 core_ref", core_ref, 0);
      chk("R10 aux_ref", aux_ref, 0);
      chk("R10 phase_cnt", phase_cnt, 0);
      chk("R10 active", active, 0);
      rst_n = 1'b1;
      wait_clk(2);

      // R1 enable edge while por low is ignored
      en = 1'b1;
      wait_clk(3);
      chk("R1 en without por", active, 0);
      en = 1'b0;
      wait_clk(2);

      // R2 phase latch on por rise, channel 4 flag -> 3
      ph_flags = 3'b100;
      por = 1'b1;
      wait_clk(2);
      chk("R2 ch4 flag", phase_cnt, 3);
      ph_flags = 3'b011;
      wait_clk(3);
      chk("R2 late flags ignored", phase_cnt, 3);

      // Parallel mode, pwrok and serial targets present but ignored
      mode_strap = 1'b1;
      pwrok = 1'b1;
      fix_en = 1'b1;
      cmd_core = 7'd0;
      cmd_aux = 7'd0;
      en = 1'b1;
      wait_clk(2);
      chk("R1 active", active, 1);
      chk("R1 par_mode", par_mode, 1);
      mode_strap = 1'b0;
      for (int i = 0; i < N_VEC; i++) begin
         par_code = PAR_VEC[i][12:7];
         wait_clk(SETTLE);
         // R3 decode, R4 pwrok ignored
         chk("R3 core code", core_ref, int'(PAR_VEC[i][6:0]));
         chk("R4 aux zero", aux_ref, 0);
         chk("R4 aux hiz", aux_hiz, 1);
      end
      chk("R1 mode held", par_mode, 1);

      // R9 enable fall clears
      en = 1'b0;
      wait_clk(3);
      chk("R9 active", active, 0);
      chk("R9 par_mode", par_mode, 0);
      chk("R9 core_ref", core_ref, 0);
      chk("R9 phase kept", phase_cnt, 3);

      // Serial mode boot, straps 01 -> 80
      pwrok = 1'b0;
      fix_en = 1'b0;
      boot_pins = 2'b01;
      en = 1'b1;
      wait_clk(2);
      boot_pins = 2'b11;
      wait_clk(10 * STEP_DIV - 2);
      // R8 ramp rate window
      total++;
      if (core_ref < 8 || core_ref > 11) begin
         bad++;
         $display("FAIL R8 ramp rate actual=%0d expected=8..11", core_ref);
      end
      wait_clk(SETTLE);
      chk("R5 boot core", core_ref, 80);
      chk("R5 boot aux", aux_ref, 80);
      chk("R1 serial mode", par_mode, 0);
      chk("R4 no hiz serial", aux_hiz, 0);

      // R6 command targets, aux off
      cmd_core = 7'd24;
      cmd_aux = 7'd124;
      pwrok = 1'b1;
      wait_clk(SETTLE);
      chk("R6 core cmd", core_ref, 100);
      chk("R6 aux off", aux_ref, 0);
      cmd_core = 7'h7F;
      cmd_aux = 7'd2;
      wait_clk(SETTLE);
      chk("R6 core off", core_ref, 0);
      chk("R6 aux cmd", aux_ref, 122);

      // R7 fixed mode overrides pwrok and follows pins live
      fix_en = 1'b1;
      boot_pins = 2'b10;
      wait_clk(SETTLE);
      chk("R7 fix 10 core", core_ref, 80);
      chk("R7 fix 10 aux", aux_ref, 80);
      boot_pins = 2'b00;
      wait_clk(SETTLE);
      chk("R7 fix 00 core", core_ref, 112);
      chk("R7 fix 00 aux", aux_ref, 112);

      // R9 por fall clears everything
      por = 1'b0;
      wait_clk(3);
      chk("R9 por active", active, 0);
      chk("R9 por phase", phase_cnt, 0);
      chk("R9 por core", core_ref, 0);
      chk("R9 por aux", aux_ref, 0);

      // R2 priority: channel 3 beats channel 4
      ph_flags = 3'b110;
      por = 1'b1;
      wait_clk(2);
      chk("R2 ch3 priority", phase_cnt, 2);
      chk("R1 no enable without edge", active, 0);
      por = 1'b0;
      wait_clk(2);
      ph_flags = 3'b000;
      por = 1'b1;
      wait_clk(2);
      chk("R2 no flag", phase_cnt, 4);
      por = 1'b0;
      wait_clk(2);
      ph_flags = 3'b111;
      por = 1'b1;
      wait_clk(2);
      chk("R2 ch2 priority", phase_cnt, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule